// File: doc/BRIEF.md
# Counting Semaphore Cell

This block is a single hardware counting semaphore used by cooperating threads to hand out and return tokens. It holds a saturating count and a mask of requesters that are waiting on it. A read through the "take" views claims one token and returns the count as it stood before the claim. A write through the "give" views returns one token and releases every waiting requester at once. The write carries no data.

Two take views are offered. The waiting take, given a count of zero, answers with a blocked response and records the requester's number in the wait mask, leaving the count untouched. The retry/scheduling logic outside the block then parks that requester until a wake pulse names it. The trying take never blocks: at zero it answers 0 and changes nothing. A raw view and a status view let software inspect the cell. The queue views, which belong to queue-type cells, do nothing here. A configuration input marks the cell as queue-type, and in that case the take and give views are inert.

The cell has one read port and one write port, so a take and a give can arrive in the same cycle. In that case the give is applied first. Every read is answered exactly one clock after it is presented.

Top module: `sem_cell`

## Requirements
- R1: After reset the count and the wait mask are zero, and `rsp_valid`, `rsp_blocked` and `wake_pulse` are low. A raw read then returns 0.
- R2: A read with view 4 (waiting take) or view 5 (trying take) is answered one cycle later. The answer is the count before the access, and the count is decremented if it was nonzero.
- R3: A view-4 read that finds the count at zero answers with `rsp_blocked`=1 and data 0. It sets bit `rd_id` of the wait mask and leaves the count unchanged.
- R4: A view-5 read that finds the count at zero answers data 0 with `rsp_blocked`=0 and changes no state.
- R5: A write with view 4 or 5 increments the count, which saturates at 0xFFFF.
- R6: A give while the wait mask is nonzero raises `wake_pulse` for one cycle in the following cycle, with `wake_mask` equal to the mask, and clears the mask. A give with an empty mask raises no pulse.
- R7: While `cfg_fifo`=1, take reads answer 0 without blocking and change nothing, and give writes are ignored.
- R8: A view-0 (raw) read returns the count. A view-0 write is ignored.
- R9: Reads with views 2, 3, 6 and 7 return 0, and writes with those views have no effect.
- R10: A view-1 (status) read returns bit0 = count is zero, bit1 = count is 0xFFFF, bit2 = `cfg_fifo`, and all other bits 0. A view-1 write is ignored.
- R11: A retried waiting take after a wake is a fresh access. If another requester has taken the token first, the retried take blocks again and is recorded again.
- R12: When a take and a give arrive in the same cycle, the give is applied first. The take, and any raw or status read in that cycle, sees the incremented count, so a take at count zero paired with a give returns 1 and does not block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fifo | input | 1 | Cell is configured as queue-type; take/give become inert |
| rd_valid | input | 1 | Read request this cycle |
| rd_view | input | 3 | View selected by the read |
| rd_id | input | $clog2(NREQ) | Number of the requester issuing the read |
| wr_valid | input | 1 | Write request this cycle |
| wr_view | input | 3 | View selected by the write |
| rsp_valid | output | 1 | Read answer valid, one cycle after the read |
| rsp_blocked | output | 1 | The answered read was a waiting take that blocked |
| rsp_data | output | DATA_W | Read answer data |
| wake_pulse | output | 1 | One-cycle release of the requesters in wake_mask |
| wake_mask | output | NREQ | Requesters released by this pulse |

## Verification
A take on the read port and a give on the write port can land in the same clock. This pairing matters most at a count of zero, where the ordering decides between blocking and succeeding. It also matters with a non-empty wait mask, where a wake must still be produced. The bench drives both ports in one cycle, first at count zero and then at a nonzero count. It judges the result from the returned value, the blocked flag, and a later raw read of the count, all against the give-first rule. A bound property independently requires a same-cycle take at zero to return 1 without blocking.

// File: rtl/sem_cell_pkg.sv
package sem_cell_pkg;

    typedef enum logic [2:0] {
        VIEW_RAW    = 3'd0,
        VIEW_STATUS = 3'd1,
        VIEW_QWAIT  = 3'd2,
        VIEW_QTRY   = 3'd3,
        VIEW_TWAIT  = 3'd4,
        VIEW_TTRY   = 3'd5
    } view_e;

    localparam int STAT_ZERO_BIT = 0;
    localparam int STAT_SAT_BIT  = 1;
    localparam int STAT_FIFO_BIT = 2;

endpackage

// File: rtl/sem_view_decode.sv
module sem_view_decode
    import sem_cell_pkg::*;
(
    input  logic       cfg_fifo,
    input  logic       rd_valid,
    input  logic [2:0] rd_view,
    input  logic       wr_valid,
    input  logic [2:0] wr_view,
    output logic       take_wait,
    output logic       take_try,
    output logic       raw_rd,
    output logic       stat_rd,
    output logic       give
);

    always_comb begin
        take_wait = 1'b0;
        take_try  = 1'b0;
        raw_rd    = 1'b0;
        stat_rd   = 1'b0;
        if (rd_valid) begin
            case (view_e'(rd_view))
                VIEW_RAW:    raw_rd    = 1'b1;
                VIEW_STATUS: stat_rd   = 1'b1;
                VIEW_TWAIT:  take_wait = !cfg_fifo;
                VIEW_TTRY:   take_try  = !cfg_fifo;
                default:     ;
            endcase
        end
    end

    always_comb begin
        give = 1'b0;
        if (wr_valid && !cfg_fifo) begin
            case (view_e'(wr_view))
                VIEW_TWAIT, VIEW_TTRY: give = 1'b1;
                default:               give = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/sem_counter.sv
module sem_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             give,
    input  logic             take,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] count_seen,
    output logic             seen_zero,
    output logic             seen_sat
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    always_comb begin
        // The give is applied ahead of any take in the same cycle.
        count_seen = count_q;
        if (give && (count_q != CNT_MAX)) begin
            count_seen = count_q + 1'b1;
        end
        seen_zero = (count_seen == '0);
        seen_sat  = (count_seen == CNT_MAX);

        state_d.count = count_seen;
        if (take && !seen_zero) begin
            state_d.count = count_seen - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign count_q = state_q.count;

endmodule

// File: rtl/sem_waiters.sv
module sem_waiters #(
    parameter int NREQ = 8,
    localparam int ID_W = $clog2(NREQ)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            give,
    input  logic            block,
    input  logic [ID_W-1:0] block_id,
    output logic [NREQ-1:0] mask_q,
    output logic            wake_pulse,
    output logic [NREQ-1:0] wake_mask
);

    typedef struct packed {
        logic [NREQ-1:0] mask;
        logic            wake;
        logic [NREQ-1:0] wake_mask;
    } wait_state_t;

    wait_state_t state_d, state_q;
    logic [NREQ-1:0] block_bit;

    always_comb begin
        block_bit = '0;
        for (int i = 0; i < NREQ; i++) begin
            if (block && (block_id == ID_W'(i))) begin
                block_bit[i] = 1'b1;
            end
        end
    end

    always_comb begin
        state_d.wake      = 1'b0;
        state_d.wake_mask = '0;
        state_d.mask      = state_q.mask;
        if (give && (state_q.mask != '0)) begin
            state_d.wake      = 1'b1;
            state_d.wake_mask = state_q.mask;
            state_d.mask      = '0;
        end
        state_d.mask = state_d.mask | block_bit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign mask_q     = state_q.mask;
    assign wake_pulse = state_q.wake;
    assign wake_mask  = state_q.wake_mask;

endmodule

// File: rtl/sem_cell.sv
module sem_cell
    import sem_cell_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NREQ   = 8,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_fifo,
    input  logic                    rd_valid,
    input  logic [2:0]              rd_view,
    input  logic [$clog2(NREQ)-1:0] rd_id,
    input  logic                    wr_valid,
    input  logic [2:0]              wr_view,
    output logic                    rsp_valid,
    output logic                    rsp_blocked,
    output logic [DATA_W-1:0]       rsp_data,
    output logic                    wake_pulse,
    output logic [NREQ-1:0]         wake_mask
);

    typedef struct packed {
        logic              valid;
        logic              blocked;
        logic [DATA_W-1:0] data;
    } rsp_t;

    logic             take_wait, take_try, raw_rd, stat_rd, give;
    logic [CNT_W-1:0] count_q, count_seen;
    logic             seen_zero, seen_sat;
    logic [NREQ-1:0]  mask_q;
    logic             block;
    rsp_t             rsp_d, rsp_q;

    sem_view_decode u_dec (
        .cfg_fifo  (cfg_fifo),
        .rd_valid  (rd_valid),
        .rd_view   (rd_view),
        .wr_valid  (wr_valid),
        .wr_view   (wr_view),
        .take_wait (take_wait),
        .take_try  (take_try),
        .raw_rd    (raw_rd),
        .stat_rd   (stat_rd),
        .give      (give)
    );

    sem_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .give       (give),
        .take       (take_wait | take_try),
        .count_q    (count_q),
        .count_seen (count_seen),
        .seen_zero  (seen_zero),
        .seen_sat   (seen_sat)
    );

    assign block = take_wait && seen_zero;

    sem_waiters #(.NREQ(NREQ)) u_wait (
        .clk        (clk),
        .rst_n      (rst_n),
        .give       (give),
        .block      (block),
        .block_id   (rd_id),
        .mask_q     (mask_q),
        .wake_pulse (wake_pulse),
        .wake_mask  (wake_mask)
    );

    always_comb begin
        rsp_d         = '0;
        rsp_d.valid   = rd_valid;
        rsp_d.blocked = block;
        if (raw_rd) begin
            rsp_d.data = DATA_W'(count_seen);
        end else if (stat_rd) begin
            rsp_d.data[STAT_ZERO_BIT] = seen_zero;
            rsp_d.data[STAT_SAT_BIT]  = seen_sat;
            rsp_d.data[STAT_FIFO_BIT] = cfg_fifo;
        end else if ((take_wait || take_try) && !block) begin
            rsp_d.data = DATA_W'(count_seen);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid   = rsp_q.valid;
    assign rsp_blocked = rsp_q.blocked;
    assign rsp_data    = rsp_q.data;

endmodule

// File: rtl/sem_cell_chk.sv
module sem_cell_chk #(
    parameter int CNT_W  = 16,
    parameter int NREQ   = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_fifo,
    input logic              rd_valid,
    input logic [2:0]        rd_view,
    input logic              wr_valid,
    input logic [2:0]        wr_view,
    input logic              rsp_valid,
    input logic              rsp_blocked,
    input logic [DATA_W-1:0] rsp_data,
    input logic              wake_pulse,
    input logic [NREQ-1:0]   wake_mask,
    input logic [CNT_W-1:0]  count_q,
    input logic [NREQ-1:0]   mask_q
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic v_give, p_any, p_wait, p_try;
    assign v_give = wr_valid && !cfg_fifo && ((wr_view == 3'd4) || (wr_view == 3'd5));
    assign p_wait = rd_valid && !cfg_fifo && (rd_view == 3'd4);
    assign p_try  = rd_valid && !cfg_fifo && (rd_view == 3'd5);
    assign p_any  = p_wait || p_try;

    // R3
    blocked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_blocked |-> (rsp_valid && (rsp_data == '0)));

    // R3
    block_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_wait && !v_give && (count_q == '0)) |=> (rsp_blocked && (count_q == '0)));

    // R4
    try_never_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && (rd_view == 3'd5)) |=> !rsp_blocked);

    // R5
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_give && !p_any && (count_q == CNT_MAX)) |=> (count_q == CNT_MAX));

    // R6
    wake_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_give && (mask_q != '0)) |=> (wake_pulse && (mask_q == '0)));

    // R6
    wake_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> (wake_mask != '0));

    // R7
    fifo_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_fifo |=> ($stable(count_q) && $stable(mask_q)));

    // R12
    pv_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_give && p_any && (count_q == '0)) |=> (!rsp_blocked && (rsp_data == 1) && (count_q == '0)));

endmodule

bind sem_cell sem_cell_chk #(.CNT_W(CNT_W), .NREQ(NREQ), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_fifo    (cfg_fifo),
    .rd_valid    (rd_valid),
    .rd_view     (rd_view),
    .wr_valid    (wr_valid),
    .wr_view     (wr_view),
    .rsp_valid   (rsp_valid),
    .rsp_blocked (rsp_blocked),
    .rsp_data    (rsp_data),
    .wake_pulse  (wake_pulse),
    .wake_mask   (wake_mask),
    .count_q     (count_q),
    .mask_q      (mask_q)
);

// File: tb/tb_sem_cell.sv
`timescale 1ns/1ps
module tb_sem_cell;

    localparam int CNT_W  = 16;
    localparam int NREQ   = 8;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_fifo = 1'b0;
    logic              rd_valid = 1'b0;
    logic [2:0]        rd_view = '0;
    logic [2:0]        rd_id = '0;
    logic              wr_valid = 1'b0;
    logic [2:0]        wr_view = '0;
    logic              rsp_valid, rsp_blocked, wake_pulse;
    logic [DATA_W-1:0] rsp_data;
    logic [NREQ-1:0]   wake_mask;

    logic              g_valid, g_blocked, g_wake;
    logic [DATA_W-1:0] g_data;
    logic [NREQ-1:0]   g_wmask;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    sem_cell #(.CNT_W(CNT_W), .NREQ(NREQ), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_fifo(cfg_fifo),
        .rd_valid(rd_valid), .rd_view(rd_view), .rd_id(rd_id),
        .wr_valid(wr_valid), .wr_view(wr_view),
        .rsp_valid(rsp_valid), .rsp_blocked(rsp_blocked), .rsp_data(rsp_data),
        .wake_pulse(wake_pulse), .wake_mask(wake_mask)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One clock: drive both ports, capture the registered answers after the edge.
    task automatic step(input logic rv, input logic [2:0] rview, input logic [2:0] rid,
                        input logic wv, input logic [2:0] wview);
        @(negedge clk);
        rd_valid = rv; rd_view = rview; rd_id = rid;
        wr_valid = wv; wr_view = wview;
        @(posedge clk);
        #1;
        g_valid = rsp_valid; g_blocked = rsp_blocked; g_data = rsp_data;
        g_wake = wake_pulse; g_wmask = wake_mask;
        rd_valid = 1'b0; wr_valid = 1'b0;
    endtask

    task automatic give_n(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 3'd0, 3'd0, 1'b1, 3'd5);
    endtask

    task automatic raw_count(output logic [31:0] v);
        step(1'b1, 3'd0, 3'd0, 1'b0, 3'd0);
        v = g_data;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cfg_fifo = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        #1;
        chk("R1", "rsp_valid", rsp_valid, 0);
        chk("R1", "wake_pulse", wake_pulse, 0);
        chk("R1", "rsp_blocked", rsp_blocked, 0);
        raw_count(v);
        chk("R1", "count", v, 0);
        step(1'b1, 3'd1, 3'd0, 1'b0, 3'd0);
        chk("R10", "status at zero", g_data, 32'h1);
    endtask

    task automatic t_take_basic();
        logic [31:0] v;
        do_reset();
        give_n(3);
        step(1'b1, 3'd4, 3'd1, 1'b0, 3'd0);
        chk("R2", "wait take valid", g_valid, 1);
        chk("R2", "wait take data", g_data, 3);
        chk("R2", "wait take blocked", g_blocked, 0);
        step(1'b1, 3'd5, 3'd2, 1'b0, 3'd0);
        chk("R2", "try take data", g_data, 2);
        raw_count(v);
        chk("R2", "count after two takes", v, 1);
    endtask

    task automatic t_block_and_wake();
        logic [31:0] v;
        do_reset();
        step(1'b1, 3'd4, 3'd3, 1'b0, 3'd0);
        chk("R3", "blocked flag", g_blocked, 1);
        chk("R3", "blocked data", g_data, 0);
        raw_count(v);
        chk("R3", "count unchanged", v, 0);
        step(1'b0, 3'd0, 3'd0, 1'b1, 3'd4);
        chk("R6", "wake pulse", g_wake, 1);
        chk("R6", "wake mask", g_wmask, 8'h08);
        step(1'b0, 3'd0, 3'd0, 1'b0, 3'd0);
        chk("R6", "pulse one cycle", g_wake, 0);
        step(1'b0, 3'd0, 3'd0, 1'b1, 3'd5);
        chk("R6", "no wake on empty mask", g_wake, 0);
        raw_count(v);
        chk("R5", "count after two gives", v, 2);
    endtask

    task automatic t_try_zero();
        logic [31:0] v;
        do_reset();
        step(1'b1, 3'd5, 3'd6, 1'b0, 3'd0);
        chk("R4", "try at zero data", g_data, 0);
        chk("R4", "try at zero blocked", g_blocked, 0);
        step(1'b0, 3'd0, 3'd0, 1'b1, 3'd4);
        chk("R4", "no waiter recorded", g_wake, 0);
        raw_count(v);
        chk("R4", "count after try+give", v, 1);
    endtask

    task automatic t_fifo_cfg();
        logic [31:0] v;
        do_reset();
        give_n(2);
        cfg_fifo = 1'b1;
        step(1'b1, 3'd4, 3'd0, 1'b0, 3'd0);
        chk("R7", "take on queue cell data", g_data, 0);
        chk("R7", "take on queue cell blocked", g_blocked, 0);
        step(1'b1, 3'd5, 3'd0, 1'b1, 3'd4);
        chk("R7", "try on queue cell", g_data, 0);
        step(1'b1, 3'd1, 3'd0, 1'b0, 3'd0);
        chk("R10", "status on queue cell", g_data, 32'h4);
        cfg_fifo = 1'b0;
        raw_count(v);
        chk("R7", "count kept", v, 2);
    endtask

    task automatic t_views();
        logic [31:0] v;
        do_reset();
        give_n(1);
        step(1'b1, 3'd2, 3'd0, 1'b1, 3'd2);
        chk("R9", "view2 read", g_data, 0);
        step(1'b1, 3'd3, 3'd0, 1'b1, 3'd3);
        chk("R9", "view3 read", g_data, 0);
        step(1'b1, 3'd6, 3'd0, 1'b1, 3'd6);
        chk("R9", "view6 read", g_data, 0);
        step(1'b1, 3'd7, 3'd0, 1'b1, 3'd7);
        chk("R9", "view7 read", g_data, 0);
        step(1'b0, 3'd0, 3'd0, 1'b1, 3'd0);
        step(1'b0, 3'd0, 3'd0, 1'b1, 3'd1);
        raw_count(v);
        chk("R8", "raw read after ignored writes", v, 1);
        step(1'b1, 3'd1, 3'd0, 1'b0, 3'd0);
        chk("R10", "status nonzero", g_data, 0);
    endtask

    task automatic t_retry();
        do_reset();
        step(1'b1, 3'd4, 3'd2, 1'b0, 3'd0);
        step(1'b1, 3'd4, 3'd5, 1'b0, 3'd0);
        chk("R3", "second waiter blocked", g_blocked, 1);
        step(1'b0, 3'd0, 3'd0, 1'b1, 3'd4);
        chk("R11", "both woken", g_wmask, 8'h24);
        step(1'b1, 3'd4, 3'd5, 1'b0, 3'd0);
        chk("R11", "first retry wins", g_data, 1);
        step(1'b1, 3'd4, 3'd2, 1'b0, 3'd0);
        chk("R11", "late retry blocks again", g_blocked, 1);
        step(1'b0, 3'd0, 3'd0, 1'b1, 3'd5);
        chk("R11", "re-recorded waiter", g_wmask, 8'h04);
    endtask

    task automatic t_same_cycle();
        logic [31:0] v;
        do_reset();
        step(1'b1, 3'd4, 3'd1, 1'b1, 3'd4);
        chk("R12", "take+give at zero data", g_data, 1);
        chk("R12", "take+give at zero blocked", g_blocked, 0);
        chk("R12", "no wake", g_wake, 0);
        raw_count(v);
        chk("R12", "count back to zero", v, 0);
        give_n(3);
        step(1'b1, 3'd5, 3'd0, 1'b1, 3'd5);
        chk("R12", "try+give at three", g_data, 4);
        step(1'b1, 3'd0, 3'd0, 1'b1, 3'd4);
        chk("R12", "raw+give sees increment", g_data, 4);
        step(1'b1, 3'd4, 3'd7, 1'b0, 3'd0);
        step(1'b1, 3'd4, 3'd7, 1'b0, 3'd0);
        step(1'b1, 3'd4, 3'd7, 1'b0, 3'd0);
        step(1'b1, 3'd4, 3'd7, 1'b0, 3'd0);
        step(1'b1, 3'd4, 3'd7, 1'b0, 3'd0);
        chk("R12", "waiter after drain", g_blocked, 1);
        step(1'b1, 3'd4, 3'd3, 1'b1, 3'd4);
        chk("R12", "take+give with waiter data", g_data, 1);
        chk("R12", "take+give with waiter wake", g_wmask, 8'h80);
    endtask

    task automatic t_saturate();
        logic [31:0] v;
        do_reset();
        give_n(65535);
        raw_count(v);
        chk("R5", "count at max", v, 32'hFFFF);
        give_n(1);
        raw_count(v);
        chk("R5", "saturated", v, 32'hFFFF);
        step(1'b1, 3'd1, 3'd0, 1'b0, 3'd0);
        chk("R10", "status saturated", g_data, 32'h2);
        step(1'b1, 3'd5, 3'd0, 1'b0, 3'd0);
        chk("R2", "take at max", g_data, 32'hFFFF);
        raw_count(v);
        chk("R2", "count after take at max", v, 32'hFFFE);
    endtask

    initial begin
        t_reset();
        t_take_basic();
        t_block_and_wake();
        t_try_zero();
        t_fifo_cfg();
        t_views();
        t_retry();
        t_same_cycle();
        t_saturate();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule